// File: doc/BRIEF.md
# Register-Mapped SPI Word Master

This block is a software-driven SPI master that moves a single 8-bit or 16-bit word each time it is started. A host reaches it through a small 32-bit register bus with separate read and write strobes and a word address. The master drives the serial clock, the serial data out and up to eight active-low device selects, and it shifts in the serial data returned by the device.

Software picks a device and asserts its select through the control register. It sets the word size, the clock polarity and phase, and the clock divider in the configuration register. A write to the transmit register starts a word. Software then polls the completion register until it reads nonzero, reads the received word, and writes zero to the completion register before it starts the next word. The timing register can move the point at which the serial input is captured one core cycle later. This helps fast links that run in polarity 1, phase 1.

The serial clock half period is (divider + 1) core clock cycles. Bits move most significant first.

Top module: `spi_word_master`

## Requirements
- R1: After reset all device selects read high, the serial clock is low, the completion register reads 0, the configuration and control registers read 0, and the timing register reads 0x40 (capture field = 1).
- R2: Registers sit at byte offsets 0x00 control, 0x04 configuration, 0x08 transmit, 0x0C receive, 0x10 completion and 0x18 timing, which are word addresses 0, 1, 2, 3, 4 and 6. Control bits 4:2 and bit 0, configuration bits 12, 11, 5 and 4:0, and timing bits 7:6 read back as written. All other bits read 0.
- R3: With control bit 0 set, only the device select numbered by control bits 4:2 is driven low. It stays low across consecutive words until bit 0 is cleared. All other selects stay high.
- R4: A write to the transmit register while idle sends one word most significant bit first. Configuration bit 5 = 1 gives 16 bits and 0 gives 8 bits (bits 7:0 of the write). The word produces exactly 2 x width serial clock edges.
- R5: The completion register reads 1 once a word has finished. A write to it with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it set.
- R6: The receive register returns the last received word in bits 15:0, with the first received bit in bit 15. In 8-bit mode the word is in bits 7:0, the first received bit is in bit 7, and bits 31:8 read 0.
- R7: The serial clock idles at configuration bit 11 (polarity). With bit 12 (phase) = 0 both ends capture on the leading edge of each clock pulse. With phase = 1 both ends capture on the trailing edge.
- R8: A write to the transmit register while a word is in progress has no effect. The word in flight, its edge count and the transmit register readback all stay as they were.
- R9: Timing bits 7:6 = 2 capture the serial input one core cycle after the capture edge. Any other value captures on the edge. Both settings receive correctly with a divider of 1 or more.
- R10: Each serial clock half period lasts (configuration bits 4:0 + 1) core clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe, 0 otherwise |
| miso | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| cs_n | output | 8 | Active-low device selects |

## Verification
The bench runs all four clock modes at both word sizes against a model of a serial device. A master that mixed up leading and trailing edges would hand back a received word shifted by one bit. One that got the bit count wrong would produce 16 or 32 edges in the wrong mode. A start write issued in the middle of a word is the main hazard, since a design that accepted it would restart and emit extra edges or change the transmit readback. The bench also covers the completion flag ignoring a write of 1, the upper receive bits staying zero in 8-bit mode, a select held across back-to-back words, and the delayed capture setting in mode 3.

// File: rtl/spi_word_master.sv
`timescale 1ns/1ps
module spi_word_master #(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int WMAX   = 16;
  localparam int ECNT_W = $clog2(2*WMAX+1);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TXD    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RXD    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(6);

  logic             cs_act;
  logic [2:0]       cs_idx;
  logic [DIV_W-1:0] div;
  logic             wide, cpol, cpha;
  logic [1:0]       smp_sel;
  logic [15:0]      txd_r, rxd_r;
  logic             cause;

  logic              busy, wide_l, sclk_r, smp_pend;
  logic [DIV_W-1:0]  hcnt;
  logic [ECNT_W-1:0] ecnt;
  logic [15:0]       tx_sh, rx_sh;

  logic wr_ctrl, wr_cfg, wr_txd, wr_cause, wr_timing, launch;
  assign wr_ctrl   = bus_wr && bus_addr == A_CTRL;
  assign wr_cfg    = bus_wr && bus_addr == A_CFG;
  assign wr_txd    = bus_wr && bus_addr == A_TXD;
  assign wr_cause  = bus_wr && bus_addr == A_CAUSE;
  assign wr_timing = bus_wr && bus_addr == A_TIMING;
  assign launch    = wr_txd && !busy;

  logic [ECNT_W-1:0] last_edge;
  logic tick, sample_ev, shift_ev, delayed, finish;
  assign last_edge = wide_l ? ECNT_W'(32) : ECNT_W'(16);
  assign tick      = busy && (ecnt != last_edge) && (hcnt == div);
  assign sample_ev = tick && (ecnt[0] == cpha);
  assign shift_ev  = tick && (cpha ? (!ecnt[0] && ecnt != '0) : ecnt[0]);
  assign delayed   = smp_sel == 2'd2;
  assign finish    = busy && (ecnt == last_edge) && !smp_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_act  <= 1'b0;
      cs_idx  <= '0;
      div     <= '0;
      wide    <= 1'b0;
      cpol    <= 1'b0;
      cpha    <= 1'b0;
      smp_sel <= 2'd1;
    end else begin
      if (wr_ctrl) begin
        cs_act <= bus_wdata[0];
        cs_idx <= bus_wdata[4:2];
      end
      if (wr_cfg) begin
        div  <= bus_wdata[DIV_W-1:0];
        wide <= bus_wdata[5];
        cpol <= bus_wdata[11];
        cpha <= bus_wdata[12];
      end
      if (wr_timing) smp_sel <= bus_wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wide_l   <= 1'b0;
      sclk_r   <= 1'b0;
      smp_pend <= 1'b0;
      hcnt     <= '0;
      ecnt     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      txd_r    <= '0;
      rxd_r    <= '0;
      cause    <= 1'b0;
    end else begin
      if (launch) begin
        busy     <= 1'b1;
        wide_l   <= wide;
        txd_r    <= wide ? bus_wdata[15:0] : {8'h00, bus_wdata[7:0]};
        tx_sh    <= wide ? bus_wdata[15:0] : {bus_wdata[7:0], 8'h00};
        rx_sh    <= '0;
        ecnt     <= '0;
        hcnt     <= '0;
        smp_pend <= 1'b0;
      end else if (busy) begin
        if (finish) begin
          busy <= 1'b0;
        end else begin
          if (tick) hcnt <= '0;
          else if (ecnt != last_edge) hcnt <= hcnt + 1'b1;
          if (tick) begin
            sclk_r <= ~sclk_r;
            ecnt   <= ecnt + 1'b1;
          end
          if (shift_ev) tx_sh <= {tx_sh[14:0], 1'b0};
          if (smp_pend || (sample_ev && !delayed)) rx_sh <= {rx_sh[14:0], miso};
          smp_pend <= sample_ev && delayed;
        end
      end else begin
        sclk_r <= cpol;
      end

      if (finish) begin
        cause <= 1'b1;
        rxd_r <= wide_l ? rx_sh : {8'h00, rx_sh[7:0]};
      end else if (wr_cause && !bus_wdata[0]) begin
        cause <= 1'b0;
      end
    end
  end

  assign sclk = sclk_r;
  assign mosi = busy & tx_sh[15];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(cs_act && cs_idx == 3'(i));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:   begin bus_rdata[4:2] = cs_idx; bus_rdata[0] = cs_act; end
        A_CFG:    begin
          bus_rdata[DIV_W-1:0] = div;
          bus_rdata[5]  = wide;
          bus_rdata[11] = cpol;
          bus_rdata[12] = cpha;
        end
        A_TXD:    bus_rdata[15:0] = txd_r;
        A_RXD:    bus_rdata[15:0] = rxd_r;
        A_CAUSE:  bus_rdata[0] = cause;
        A_TIMING: bus_rdata[7:6] = smp_sel;
        default:  bus_rdata = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:13], bus_wdata[10:8], bus_wdata[1]};
endmodule

// File: rtl/spi_word_master_chk.sv
`timescale 1ns/1ps
module spi_word_master_chk #(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 3,
  parameter int ECNT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sclk,
  input logic              cpol,
  input logic              cause,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       txd_r,
  input logic [ECNT_W-1:0] ecnt,
  input logic              wide_l
);
  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(cpol)) |-> sclk == cpol);

  assert_cause_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cause);

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == ADDR_W'(2)) |=> $stable(txd_r));

  assert_edge_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ecnt <= (wide_l ? ECNT_W'(32) : ECNT_W'(16)));
endmodule

bind spi_word_master spi_word_master_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .ECNT_W(ECNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .sclk(sclk), .cpol(cpol),
  .cause(cause), .bus_wr(bus_wr), .bus_addr(bus_addr), .txd_r(txd_r),
  .ecnt(ecnt), .wide_l(wide_l)
);

// File: tb/test_spi_word_master.sv
`timescale 1ns/1ps
module test_spi_word_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic miso = 1'b0;
  logic sclk, mosi;
  logic [7:0] cs_n;

  always #2 clk = ~clk;

  spi_word_master i_spi_word_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .miso(miso), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n)
  );

  int nvec = 0, nbad = 0, cyc = 0;
  bit done_flag = 0;
  always @(posedge clk) cyc++;

  // serial device model
  logic s_cpol = 0, s_cpha = 0;
  int s_n = 8, s_lead = 0, s_trail = 0, s_edges = 0;
  int s_last_t = 0, s_min_gap = 0, s_max_gap = 0;
  logic [15:0] s_tx = '0, s_rx = '0;

  always @(posedge sclk or negedge sclk) begin
    if (s_edges > 0) begin
      if (s_min_gap == 0 || cyc - s_last_t < s_min_gap) s_min_gap = cyc - s_last_t;
      if (cyc - s_last_t > s_max_gap) s_max_gap = cyc - s_last_t;
    end
    s_last_t = cyc;
    s_edges++;
    if (sclk != s_cpol) begin
      if (!s_cpha) s_rx = {s_rx[14:0], mosi};
      else if (s_lead < s_n) miso = s_tx[s_n-1-s_lead];
      s_lead++;
    end else begin
      if (s_cpha) s_rx = {s_rx[14:0], mosi};
      else if (s_trail < s_n-1) miso = s_tx[s_n-2-s_trail];
      s_trail++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic prep_dev(logic cp, logic ph, int n, logic [15:0] stx);
    @(negedge clk);
    @(negedge clk);
    s_cpol = cp; s_cpha = ph; s_n = n; s_tx = stx; s_rx = '0;
    s_lead = 0; s_trail = 0; s_edges = 0; s_min_gap = 0; s_max_gap = 0;
    miso = stx[n-1];
  endtask

  task automatic wait_done(string req);
    logic [31:0] v = '0;
    for (int k = 0; k < 400 && v == 0; k++) bus_read(3'd4, v);
    check(req, v, 32'h1);
  endtask

  task automatic run_word(logic cp, logic ph, logic wd, int dv, logic [15:0] tx,
                          logic [15:0] stx, string tag);
    int n = wd ? 16 : 8;
    logic [15:0] mask = wd ? 16'hFFFF : 16'h00FF;
    logic [31:0] v;
    bus_write(3'd1, 32'(dv) | (32'(wd) << 5) | (32'(cp) << 11) | (32'(ph) << 12));
    prep_dev(cp, ph, n, stx);
    bus_write(3'd2, {16'h0, tx});
    wait_done({tag, " R5 done"});
    check({tag, " R4 device got word"}, {16'h0, s_rx & mask}, {16'h0, tx & mask});
    check({tag, " R4 edge count"}, s_edges, 2*n);
    bus_read(3'd3, v);
    check({tag, " R6 receive word"}, v, {16'h0, stx & mask});
    check({tag, " R7 sclk idle"}, {31'h0, sclk}, {31'h0, cp});
    check({tag, " R10 min half period"}, s_min_gap, dv+1);
    check({tag, " R10 max half period"}, s_max_gap, dv+1);
    bus_write(3'd4, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 cs_n", {24'h0, cs_n}, 32'hFF);
    check("R1 sclk", {31'h0, sclk}, 32'h0);
    bus_read(3'd4, v); check("R1 cause", v, 32'h0);
    bus_read(3'd6, v); check("R1 timing", v, 32'h40);
    bus_read(3'd1, v); check("R1 cfg", v, 32'h0);
    bus_read(3'd0, v); check("R1 ctrl", v, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    bus_write(3'd1, 32'hFFFF_FFFF);
    bus_read(3'd1, v); check("R2 cfg readback", v, 32'h0000_183F);
    bus_write(3'd6, 32'hFFFF_FF80);
    bus_read(3'd6, v); check("R2 timing readback", v, 32'h80);
    bus_write(3'd6, 32'h40);
    bus_write(3'd1, 32'h0);
    bus_write(3'd0, 32'hFFFF_FFF5);
    bus_read(3'd0, v); check("R2 ctrl readback", v, 32'h15);
    check("R3 select 5", {24'h0, cs_n}, 32'hDF);
  endtask

  task automatic t_modes;
    run_word(0, 0, 0, 0, 16'h00A5, 16'h003C, "mode0 8b");
    check("R3 held after word", {24'h0, cs_n}, 32'hDF);
    run_word(0, 1, 0, 2, 16'h0096, 16'h00C3, "mode1 8b");
    run_word(1, 0, 1, 1, 16'hBEEF, 16'h1234, "mode2 16b");
    run_word(1, 1, 1, 3, 16'h8001, 16'hF00D, "mode3 16b");
    check("R3 held across words", {24'h0, cs_n}, 32'hDF);
    run_word(0, 0, 0, 1, 16'hFF81, 16'hAB7E, "R6 upper zero 8b");
  endtask

  task automatic t_cause;
    logic [31:0] v;
    bus_write(3'd1, 32'h1);
    prep_dev(0, 0, 8, 16'h0055);
    bus_write(3'd2, 32'h5A);
    wait_done("R5 set");
    bus_write(3'd4, 32'h1);
    bus_read(3'd4, v); check("R5 write 1 keeps flag", v, 32'h1);
    bus_write(3'd4, 32'h0);
    bus_read(3'd4, v); check("R5 write 0 clears", v, 32'h0);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    bus_write(3'd1, 32'h3);
    prep_dev(0, 0, 8, 16'h0000);
    bus_write(3'd2, 32'h81);
    repeat (4) @(negedge clk);
    bus_write(3'd2, 32'h7E);
    wait_done("R8 done");
    check("R8 word unchanged", {16'h0, s_rx & 16'hFF}, 32'h81);
    check("R8 no extra edges", s_edges, 16);
    bus_read(3'd2, v); check("R8 transmit readback", v, 32'h81);
    bus_write(3'd4, 32'h0);
  endtask

  task automatic t_timing;
    bus_write(3'd6, 32'h80);
    run_word(1, 1, 1, 1, 16'h5AA5, 16'hC0DE, "R9 delayed mode3");
    run_word(0, 0, 0, 2, 16'h0033, 16'h00E7, "R9 delayed mode0");
    bus_write(3'd6, 32'h40);
    run_word(1, 1, 1, 1, 16'h0F0F, 16'h9669, "R9 normal mode3");
  endtask

  task automatic t_select;
    bus_write(3'd0, 32'h10);
    check("R3 deasserted", {24'h0, cs_n}, 32'hFF);
    bus_write(3'd0, 32'h1D);
    check("R3 select 7", {24'h0, cs_n}, 32'h7F);
    bus_write(3'd0, 32'h1);
    check("R3 select 0", {24'h0, cs_n}, 32'hFE);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    nvec++; nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_modes();
    t_cause();
    t_busy();
    t_timing();
    t_select();
    finish_run();
  end
endmodule